// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

A 16-bit down-counting timer on a small memory-mapped register bus. It counts enable pulses from a slow oscillator through a selectable prescaler. In its general-purpose mode it counts down from a reload value. Each time a prescaled tick finds the count at zero, the counter reloads and a level interrupt is raised. Software acknowledges that interrupt by writing the clear register.

Setting the watchdog bit of the configuration register moves the mode state machine from state `MODE_NORMAL` to state `MODE_WATCH`. That transition reloads the counter. Once in `MODE_WATCH`, software must write the clear register (any data) before the count runs out. If it does not, the block raises either a one-cycle system reset request or the level interrupt, as configuration bit 1 selects. The only transitions are `MODE_NORMAL -> MODE_NORMAL` (hold), `MODE_NORMAL -> MODE_WATCH` (an accepted configuration write with bit 5 set) and `MODE_WATCH -> MODE_WATCH` (hold). Only power-on reset leaves `MODE_WATCH`. In that state the load and configuration registers are frozen, and the synchronous system reset input has no effect. Counting freezes while the debug-halt input is high. It can optionally freeze while the power-down input is high.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset, the load register and the count both read 0x0040, the configuration reads 0x0000, and irq, the reset request and rdata are low.
- R2: Every prescaled tick decrements the count by one. A tick that finds the count at 0 reloads it from the load register instead, so one period is load+1 prescaled ticks. In normal mode that tick sets irq.
- R3: Configuration bits 3:2 set the prescaler: 00 divides by 1, 01 by 16, and both 10 and 11 by 256. The prescaler phase restarts on every accepted configuration write, on every counter reload from the bus, and on a system reset taken in normal mode.
- R4: An accepted configuration write with bit 5 set enters watchdog mode. The counter reloads from the load register, and configuration readback shows bit 5 set.
- R5: In watchdog mode with configuration bit 1 = 0, an expiry produces wdt_rst_req high for exactly one cycle and reloads the count. irq is not set.
- R6: In watchdog mode with configuration bit 1 = 1, an expiry sets irq, and irq stays high until the clear register is written. No reset request is produced.
- R7: In watchdog mode, a write to the clear register (offset 0x0C, data ignored) reloads the count from the load register and restarts the prescaler. If it comes in the same cycle as an expiring tick, the write wins and no expiry occurs.
- R8: In normal mode, a clear write drops irq and leaves the count alone. If an expiring tick comes in the same cycle, irq is set.
- R9: In watchdog mode, writes to the load register (0x00) and the configuration register (0x08) are ignored. Readback and expiry timing are unchanged.
- R10: A high sys_rst at a clock edge in normal mode returns the load register, configuration, count and irq to their reset values. In watchdog mode it has no effect.
- R11: While dbg_halt is high, the count and the prescaler phase do not advance.
- R12: With configuration bit 0 = 0, counting continues while pwr_down is high. With bit 0 = 1, counting stops while pwr_down is high.
- R13: A read strobe loads rdata at the next edge, and rdata holds until the next read. Offset 0x00 returns load, 0x04 the count, 0x08 the configuration ({bit5 watchdog, bits3:2 prescale, bit1 expiry select, bit0 power-down stop}, others 0), and 0x0C returns 0. Writes to 0x04 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous non-power-on reset, active high |
| osc_tick | input | 1 | One-cycle enable per slow oscillator period |
| dbg_halt | input | 1 | Debug halt, freezes counting |
| pwr_down | input | 1 | Power-down indication |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| wdt_rst_req | output | 1 | One-cycle system reset request |
| tmr_irq | output | 1 | Level interrupt |

## Verification
The counting core is driven by ticks on every cycle and by sparse random ticks, under each prescaler code. The expiry spacing tells apart divide by 1, 16 and 256, and shows whether the period is load or load+1. Refresh writes are placed both well before expiry and in the very cycle of an expiring tick, which separates the clear-wins rule of watchdog mode from the set-wins rule of normal mode. Random mixes of halts, power-down, system resets and register writes, taken before and after the lock, show which stimuli are ignored once watchdog mode is entered and which still act on the count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_WATCH  = 1'b1
    } wd_mode_e;

    typedef struct packed {
        logic [1:0] presc;
        logic       expire_irq;
        logic       stop_pd;
    } wd_cfg_t;

    localparam int OFS_LOAD  = 'h0;
    localparam int OFS_VALUE = 'h4;
    localparam int OFS_CFG   = 'h8;
    localparam int OFS_CLEAR = 'hC;

    localparam int CFG_STOP_PD = 0;
    localparam int CFG_EXP_IRQ = 1;
    localparam int CFG_PRE_LO  = 2;
    localparam int CFG_PRE_HI  = 3;
    localparam int CFG_WATCH   = 5;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRE_W = 8,
    parameter int MID_W = 4
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       phase_clr_i,
    input  logic       tick_i,
    input  logic       run_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);
    localparam int NTAP = 3;

    logic [PRE_W-1:0] phase_q;
    logic [NTAP-1:0]  tap_hit;
    logic             hit;

    assign tap_hit[0] = 1'b1;

    for (genvar k = 1; k < NTAP; k++) begin : g_tap
        localparam int TW = (k == 1) ? MID_W : PRE_W;
        assign tap_hit[k] = &phase_q[TW-1:0];
    end

    always_comb begin
        unique case (sel_i)
            2'b00:   hit = tap_hit[0];
            2'b01:   hit = tap_hit[1];
            default: hit = tap_hit[2];
        endcase
    end

    assign tick_o = tick_i & run_i & hit;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            phase_q <= '0;
        end else if (phase_clr_i) begin
            phase_q <= '0;
        end else if (tick_i && run_i) begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int              CNT_W   = 16,
    parameter logic [CNT_W-1:0] RST_VAL = 16'h0040
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             init_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] value_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] count_q;
    logic             at_zero;

    assign at_zero  = (count_q == '0);
    assign expire_o = step_i & at_zero & ~reload_i & ~init_i;
    assign value_o  = count_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            count_q <= RST_VAL;
        end else if (init_i) begin
            count_q <= RST_VAL;
        end else if (reload_i) begin
            count_q <= load_i;
        end else if (step_i) begin
            count_q <= at_zero ? load_i : count_q - 1'b1;
        end
    end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int               CNT_W   = 16,
    parameter int               ADDR_W  = 4,
    parameter logic [CNT_W-1:0] RST_VAL = 16'h0040
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic [CNT_W-1:0]  value_i,
    input  logic              expire_i,
    output wd_cfg_t           cfg_o,
    output logic [CNT_W-1:0]  load_o,
    output logic              watch_o,
    output logic              reload_o,
    output logic              init_o,
    output logic              phase_clr_o,
    output logic              irq_o,
    output logic              rst_req_o,
    output logic [CNT_W-1:0]  rdata_o
);
    wd_mode_e         state_q, state_d;
    wd_cfg_t          cfg_q;
    logic [CNT_W-1:0] load_q;
    logic             irq_q, rst_q;
    logic [CNT_W-1:0] rdata_q;

    logic hit_load, hit_value, hit_cfg, hit_clear;
    logic cfg_we, load_we, clr_we;
    logic irq_set;
    logic [CNT_W-1:0] cfg_word;

    assign hit_load  = (addr_i == ADDR_W'(OFS_LOAD));
    assign hit_value = (addr_i == ADDR_W'(OFS_VALUE));
    assign hit_cfg   = (addr_i == ADDR_W'(OFS_CFG));
    assign hit_clear = (addr_i == ADDR_W'(OFS_CLEAR));
    assign clr_we    = wr_i & hit_clear;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= MODE_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        unique case (state_q)
            MODE_NORMAL: state_d = (cfg_we && wdata_i[CFG_WATCH]) ? MODE_WATCH : MODE_NORMAL;
            MODE_WATCH:  state_d = MODE_WATCH;
            default:     state_d = MODE_NORMAL;
        endcase
    end

    // outputs of the mode machine
    always_comb begin
        unique case (state_q)
            MODE_NORMAL: begin
                cfg_we   = wr_i & hit_cfg & ~sys_rst_i;
                load_we  = wr_i & hit_load & ~sys_rst_i;
                reload_o = cfg_we & wdata_i[CFG_WATCH];
                init_o   = sys_rst_i;
                irq_set  = expire_i;
                watch_o  = 1'b0;
            end
            MODE_WATCH: begin
                cfg_we   = 1'b0;
                load_we  = 1'b0;
                reload_o = clr_we;
                init_o   = 1'b0;
                irq_set  = expire_i & cfg_q.expire_irq;
                watch_o  = 1'b1;
            end
            default: begin
                cfg_we   = 1'b0;
                load_we  = 1'b0;
                reload_o = 1'b0;
                init_o   = 1'b0;
                irq_set  = 1'b0;
                watch_o  = 1'b0;
            end
        endcase
    end

    assign phase_clr_o = init_o | cfg_we | reload_o;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            load_q <= RST_VAL;
            cfg_q  <= '0;
        end else if (init_o) begin
            load_q <= RST_VAL;
            cfg_q  <= '0;
        end else begin
            if (load_we) begin
                load_q <= wdata_i;
            end
            if (cfg_we) begin
                cfg_q.stop_pd    <= wdata_i[CFG_STOP_PD];
                cfg_q.expire_irq <= wdata_i[CFG_EXP_IRQ];
                cfg_q.presc      <= wdata_i[CFG_PRE_HI:CFG_PRE_LO];
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            irq_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            rst_q <= expire_i & watch_o & ~cfg_q.expire_irq;
            if (init_o) begin
                irq_q <= 1'b0;
            end else if (irq_set) begin
                irq_q <= 1'b1;
            end else if (clr_we) begin
                irq_q <= 1'b0;
            end
        end
    end

    always_comb begin
        cfg_word                        = '0;
        cfg_word[CFG_STOP_PD]           = cfg_q.stop_pd;
        cfg_word[CFG_EXP_IRQ]           = cfg_q.expire_irq;
        cfg_word[CFG_PRE_HI:CFG_PRE_LO] = cfg_q.presc;
        cfg_word[CFG_WATCH]             = watch_o;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            if (hit_load) begin
                rdata_q <= load_q;
            end else if (hit_value) begin
                rdata_q <= value_i;
            end else if (hit_cfg) begin
                rdata_q <= cfg_word;
            end else begin
                rdata_q <= '0;
            end
        end
    end

    assign cfg_o     = cfg_q;
    assign load_o    = load_q;
    assign irq_o     = irq_q;
    assign rst_req_o = rst_q;
    assign rdata_o   = rdata_q;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int               CNT_W    = 16,
    parameter int               PRE_W    = 8,
    parameter int               MID_W    = 4,
    parameter int               ADDR_W   = 4,
    parameter logic [CNT_W-1:0] LOAD_RST = 16'h0040
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst,
    input  logic              osc_tick,
    input  logic              dbg_halt,
    input  logic              pwr_down,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              wdt_rst_req,
    output logic              tmr_irq
);
    wd_cfg_t          cfg;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cur_val;
    logic             watch_mode;
    logic             reload, init, phase_clr, expire;
    logic             run, ptick;

    assign run = ~dbg_halt & ~(pwr_down & cfg.stop_pd);

    wdog_ctrl #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .RST_VAL(LOAD_RST)
    ) u_ctrl (
        .clk        (clk),
        .por_n      (por_n),
        .sys_rst_i  (sys_rst),
        .wr_i       (bus_wr),
        .rd_i       (bus_rd),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .value_i    (cur_val),
        .expire_i   (expire),
        .cfg_o      (cfg),
        .load_o     (load_val),
        .watch_o    (watch_mode),
        .reload_o   (reload),
        .init_o     (init),
        .phase_clr_o(phase_clr),
        .irq_o      (tmr_irq),
        .rst_req_o  (wdt_rst_req),
        .rdata_o    (bus_rdata)
    );

    wdog_prescaler #(
        .PRE_W(PRE_W),
        .MID_W(MID_W)
    ) u_pre (
        .clk        (clk),
        .por_n      (por_n),
        .phase_clr_i(phase_clr),
        .tick_i     (osc_tick),
        .run_i      (run),
        .sel_i      (cfg.presc),
        .tick_o     (ptick)
    );

    wdog_counter #(
        .CNT_W  (CNT_W),
        .RST_VAL(LOAD_RST)
    ) u_cnt (
        .clk     (clk),
        .por_n   (por_n),
        .init_i  (init),
        .reload_i(reload),
        .load_i  (load_val),
        .step_i  (ptick),
        .value_o (cur_val),
        .expire_o(expire)
    );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
    import wdog_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              por_n,
    input logic              sys_rst,
    input logic              dbg_halt,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              tmr_irq,
    input logic              wdt_rst_req,
    input logic              watch_mode,
    input logic [CNT_W-1:0]  load_val,
    input logic [CNT_W-1:0]  cur_val
);
    logic clr_wr;
    assign clr_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CLEAR));

    assert_reset_only_watch_R5: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_req |-> watch_mode);

    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!por_n)
        watch_mode |=> watch_mode);

    assert_load_frozen_R9: assert property (@(posedge clk) disable iff (!por_n)
        watch_mode |=> $stable(load_val));

    assert_halt_freeze_R11: assert property (@(posedge clk) disable iff (!por_n)
        (dbg_halt && !bus_wr && !sys_rst) |=> $stable(cur_val));

    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!por_n)
        $fell(tmr_irq) |-> ($past(clr_wr) || $past(sys_rst && !watch_mode)));

endmodule

bind wdog_timer wdog_checker #(
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .sys_rst    (sys_rst),
    .dbg_halt   (dbg_halt),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .tmr_irq    (tmr_irq),
    .wdt_rst_req(wdt_rst_req),
    .watch_mode (watch_mode),
    .load_val   (load_val),
    .cur_val    (cur_val)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst = 1'b0;
    logic        osc_tick = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        pwr_down = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        wdt_rst_req;
    logic        tmr_irq;

    int checks = 0;
    int errors = 0;

    // bench model of the requirements
    logic [15:0] m_load, m_val, m_rdata;
    logic        m_stop, m_eirq, m_watch, m_irq, m_rst;
    logic [1:0]  m_presc;
    int          m_pre;

    always #2 clk = ~clk;

    wdog_timer i_wdog_timer (
        .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .osc_tick(osc_tick),
        .dbg_halt(dbg_halt), .pwr_down(pwr_down), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_req(wdt_rst_req), .tmr_irq(tmr_irq)
    );

    function automatic logic [15:0] cfg_word();
        logic [15:0] w = 16'h0;
        w[0] = m_stop; w[1] = m_eirq; w[3:2] = m_presc; w[5] = m_watch;
        return w;
    endfunction

    function automatic int divisor(input logic [1:0] p);
        return (p == 2'b00) ? 1 : (p == 2'b01) ? 16 : 256;
    endfunction

    task automatic model_reset();
        m_load = 16'h0040; m_val = 16'h0040; m_rdata = 16'h0;
        m_stop = 0; m_eirq = 0; m_watch = 0; m_irq = 0; m_rst = 0;
        m_presc = 2'b00; m_pre = 0;
    endtask

    task automatic model_edge();
        bit hl, hv, hc, hx, run, ptick, sysr, cfg_acc, reload, expire;
        int dv;
        hl = (bus_addr == 4'h0); hv = (bus_addr == 4'h4);
        hc = (bus_addr == 4'h8); hx = (bus_addr == 4'hC);
        run = osc_tick && !dbg_halt && !(pwr_down && m_stop);
        dv = divisor(m_presc);
        ptick = run && ((m_pre % dv) == dv - 1);
        sysr = sys_rst && !m_watch;
        cfg_acc = bus_wr && hc && !m_watch && !sys_rst;
        reload = (bus_wr && hx && m_watch) || (cfg_acc && bus_wdata[5]);
        expire = ptick && (m_val == 16'h0) && !reload && !sysr;
        if (bus_rd) m_rdata = hl ? m_load : hv ? m_val : hc ? cfg_word() : 16'h0;
        m_rst = expire && m_watch && !m_eirq;
        if (sysr) m_irq = 0;
        else if (expire && (!m_watch || m_eirq)) m_irq = 1;
        else if (bus_wr && hx) m_irq = 0;
        if (sysr || cfg_acc || reload) m_pre = 0;
        else if (run) m_pre = (m_pre + 1) % 256;
        if (sysr) m_val = 16'h0040;
        else if (reload) m_val = m_load;
        else if (ptick) m_val = (m_val == 16'h0) ? m_load : m_val - 16'h1;
        if (sysr) begin
            m_load = 16'h0040; m_stop = 0; m_eirq = 0; m_presc = 2'b00;
        end else begin
            if (bus_wr && hl && !m_watch) m_load = bus_wdata;
            if (cfg_acc) begin
                m_stop = bus_wdata[0]; m_eirq = bus_wdata[1];
                m_presc = bus_wdata[3:2]; m_watch = bus_wdata[5];
            end
        end
    endtask

    task automatic check16(input string tag, input string what,
                           input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one clock: inputs already driven; update model at the edge, compare after
    task automatic cycle(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check16(tag, "irq", {15'h0, tmr_irq}, {15'h0, m_irq});
        check16(tag, "rst_req", {15'h0, wdt_rst_req}, {15'h0, m_rst});
        check16(tag, "rdata", bus_rdata, m_rdata);
        bus_wr = 0; bus_rd = 0; sys_rst = 0; osc_tick = 0;
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            osc_tick = 1;
            cycle(tag);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input string tag);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        cycle(tag);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        bus_rd = 1; bus_addr = a;
        cycle(tag);
    endtask

    task automatic por();
        @(negedge clk);
        por_n = 0; bus_wr = 0; bus_rd = 0; sys_rst = 0; osc_tick = 0;
        dbg_halt = 0; pwr_down = 0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        por_n = 1;
    endtask

    task automatic rand_phase(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            int r;
            osc_tick = ($urandom % 2) == 0;
            dbg_halt = ($urandom % 20) == 0;
            pwr_down = ($urandom % 10) == 0;
            sys_rst  = ($urandom % 100) == 0;
            r = $urandom % 100;
            if (r < 6) begin
                bus_wr = 1; bus_addr = 4'hC; bus_wdata = 16'($urandom);
            end else if (r < 9) begin
                bus_wr = 1; bus_addr = 4'h0; bus_wdata = 16'($urandom % 8);
            end else if (r < 11) begin
                bus_wr = 1; bus_addr = 4'h8; bus_wdata = 16'($urandom) & 16'hFFDF;
            end else if (r < 22) begin
                bus_rd = 1; bus_addr = 4'(($urandom % 4) * 4);
            end
            cycle(tag);
        end
        dbg_halt = 0; pwr_down = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        por();
        // R1 reset values
        @(negedge clk);
        check16("R1", "irq", {15'h0, tmr_irq}, 16'h0);
        check16("R1", "rst_req", {15'h0, wdt_rst_req}, 16'h0);
        check16("R1", "rdata", bus_rdata, 16'h0);
        rd(4'h0, "R1"); check16("R1", "load", bus_rdata, 16'h0040);
        rd(4'h4, "R1"); check16("R1", "value", bus_rdata, 16'h0040);
        rd(4'h8, "R1"); check16("R1", "cfg", bus_rdata, 16'h0000);
        // R13 read-only value, write-only clear
        wr(4'h4, 16'h1234, "R13");
        rd(4'h4, "R13"); check16("R13", "value after write", bus_rdata, 16'h0040);
        rd(4'hC, "R13"); check16("R13", "clear read", bus_rdata, 16'h0000);
        // R2 normal-mode counting and reload
        wr(4'h0, 16'h0003, "R2");
        ticks(70, "R2");
        rd(4'h4, "R2");
        wr(4'hC, 16'h0, "R8");
        ticks(3, "R8");
        rd(4'h4, "R8");
        ticks(9, "R2");
        wr(4'hC, 16'h5A, "R8");
        // R8 clear and expiry in the same cycle: set wins
        for (int i = 0; i < 12; i++) begin
            osc_tick = 1; bus_wr = 1; bus_addr = 4'hC; bus_wdata = 16'h0;
            cycle("R8");
        end
        // R3 prescaler codes
        wr(4'h8, 16'h0004, "R3"); ticks(140, "R3"); rd(4'h4, "R3");
        wr(4'h8, 16'h0008, "R3"); ticks(1100, "R3"); rd(4'h4, "R3");
        wr(4'h8, 16'h000C, "R3"); ticks(1100, "R3"); rd(4'h8, "R3");
        wr(4'h8, 16'h0000, "R3");
        // R11 debug halt
        dbg_halt = 1; ticks(20, "R11"); rd(4'h4, "R11"); dbg_halt = 0;
        ticks(2, "R11"); rd(4'h4, "R11");
        // R12 power-down
        pwr_down = 1; ticks(5, "R12"); rd(4'h4, "R12");
        wr(4'h8, 16'h0001, "R12"); pwr_down = 1; ticks(6, "R12"); rd(4'h4, "R12");
        pwr_down = 0; ticks(2, "R12"); rd(4'h4, "R12");
        // R10 system reset in normal mode
        wr(4'h0, 16'h0005, "R10"); wr(4'h8, 16'h0006, "R10");
        sys_rst = 1; cycle("R10");
        rd(4'h0, "R10"); check16("R10", "load", bus_rdata, 16'h0040);
        rd(4'h8, "R10"); check16("R10", "cfg", bus_rdata, 16'h0000);
        rd(4'h4, "R10"); check16("R10", "value", bus_rdata, 16'h0040);
        // random normal-mode traffic
        rand_phase(4000, "R2");
        // R4/R5 watchdog with reset outcome
        wr(4'h0, 16'h0004, "R4");
        wr(4'h8, 16'h0020, "R4");
        rd(4'h8, "R4"); check16("R4", "cfg", bus_rdata, 16'h0020);
        rd(4'h4, "R4"); check16("R4", "value", bus_rdata, 16'h0004);
        ticks(12, "R5");
        // R7 refresh keeps it alive; refresh in the expiring cycle wins
        for (int i = 0; i < 5; i++) begin ticks(3, "R7"); wr(4'hC, 16'hFF, "R7"); end
        ticks(4, "R7");
        osc_tick = 1; bus_wr = 1; bus_addr = 4'hC; bus_wdata = 16'h0; cycle("R7");
        rd(4'h4, "R7"); check16("R7", "value", bus_rdata, 16'h0004);
        // R9 locked writes, R10 ignored system reset
        wr(4'h0, 16'h0100, "R9"); wr(4'h8, 16'h0003, "R9");
        rd(4'h0, "R9"); check16("R9", "load", bus_rdata, 16'h0004);
        rd(4'h8, "R9"); check16("R9", "cfg", bus_rdata, 16'h0020);
        ticks(10, "R9");
        sys_rst = 1; cycle("R10");
        rd(4'h8, "R10"); check16("R10", "cfg locked", bus_rdata, 16'h0020);
        rd(4'h4, "R10");
        rand_phase(2000, "R9");
        // R6 watchdog interrupt outcome, divide by 16
        por();
        wr(4'h0, 16'h0002, "R6"); wr(4'h8, 16'h0026, "R6");
        ticks(60, "R6");
        check16("R6", "irq held", {15'h0, tmr_irq}, 16'h1);
        ticks(40, "R6");
        wr(4'hC, 16'h0, "R6");
        rand_phase(2000, "R6");
        // R3 divide by 256 with code 10 and code 11 in watchdog mode
        por();
        wr(4'h0, 16'h0001, "R3"); wr(4'h8, 16'h002A, "R3"); ticks(1100, "R3");
        por();
        wr(4'h0, 16'h0001, "R3"); wr(4'h8, 16'h002C, "R3"); ticks(1100, "R3");
        rd(4'h4, "R3");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule